// File: doc/BRIEF.md
# Three-Tier Grouped Interrupt Arbiter

This block gathers interrupt request lines from three fixed-priority groups (critical, main and peripheral) and condenses them into a single 32-bit status word. The word has one field per group. Each field holds the number of the winning source in that group and a valid flag. An interrupt handler reads the word once and walks the fields in group order: critical first, then main, then peripheral. It services the first valid field it finds. The main and peripheral groups each have a disable mask. The critical group has no mask.

Any peripheral source can be given a boost level. A medium boost makes the source also appear as a reserved code in the main field. A high boost makes it appear as a reserved code in the critical field. When the reader sees either reserved code, it takes the source number from the peripheral field, which then names the boosted source in preference to unboosted ones.

Requests are sampled into registers on every clock edge. The status word is formed combinationally from those samples and from the mask and boost registers. A simple write port updates the masks and boost settings, and a read port returns them together with the status word.

Top module: `irq_tier_arbiter`

## Requirements
- R1: After reset, the main mask reads 0x0001FFFF & 0x00010FFF = 0x00010FFF, the peripheral mask reads 0x7FFFFC00, and both boost words read 0.
- R2: The register addresses are as follows:
  - Address 0 holds the main mask. Only bits 16:0 are stored.
  - Address 1 holds the peripheral mask. Only bits 31:10 are stored.
  - Address 2 holds the boosts of peripheral sources 0..15, with source n in bits 2n+1:2n.
  - Address 3 holds the boosts of sources 16..21, with source n in bits 2(n-16)+1:2(n-16).
  - Address 4 reads the status word. Writes to address 4 or above are ignored.
  - Unstored bits read 0.
- R3: The status word layout is as follows:
  - Bit 10 is the critical valid flag, with the critical code in bits 9:8.
  - Bit 21 is the main valid flag, with the main code in bits 20:16.
  - Bit 29 is the peripheral valid flag, with the peripheral code in bits 28:24.
  - All other bits are 0.
- R4: A request appears in the status word after the first rising clock edge that samples it, and not before.
- R5: Critical request lines 0, 1 and 2 report codes 0, 1 and 3. Code 2 is reported when any unmasked, pending peripheral source has boost 2 (high). The lowest pending code wins.
- R6: Main line n (0..16) is disabled by main mask bit 16-n. Request line 4 is ignored. Code 4 is reported when any unmasked, pending peripheral source has boost 1 (medium), unless main mask bit 12 is set. The lowest pending code wins.
- R7: Peripheral source n (0..21) is disabled by peripheral mask bit 31-n. Boost codes are 0 = none, 1 = medium, 2 = high, 3 = none. Among unmasked pending sources, the peripheral field reports the following, in order of preference:
  - the lowest-numbered high source;
  - otherwise the lowest-numbered medium source;
  - otherwise the lowest-numbered source.
- R8: A field whose group has nothing eligible has its valid flag clear and its code bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crit_req | input | 3 | Critical group request lines |
| main_req | input | 17 | Main group request lines (line 4 unused) |
| periph_req | input | 22 | Peripheral group request lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| status | output | 32 | Encoded pending-source word |

## Verification
The assertions assume that request lines and the write port change only between clock edges, and that reset is held for at least one edge before the checks begin. They also assume that a reported code always indexes an implemented source, so a valid peripheral code is below 22. The stimulus drives every input on the falling clock edge and samples outputs one half cycle after the rising edge. It also keeps every mask write within the defined address range, except for the deliberate writes that test ignored addresses.

// File: rtl/arbx_pkg.sv
package arbx_pkg;
  localparam int NUM_CRIT   = 3;
  localparam int NUM_MAIN   = 17;
  localparam int NUM_PERIPH = 22;
  localparam int CODE_W     = 5;
  localparam int BOOST_W    = 2 * NUM_PERIPH;
  localparam int CRIT_CODES = NUM_CRIT + 1;

  // reserved redirect codes
  localparam int CRIT_BOOST_CODE = 2;
  localparam int MAIN_BOOST_CODE = 4;

  // status word field positions
  localparam int CV_BIT = 10;
  localparam int CC_LSB = 8;
  localparam int MV_BIT = 21;
  localparam int MC_LSB = 16;
  localparam int PV_BIT = 29;
  localparam int PC_LSB = 24;

  // register addresses
  localparam int ADR_MAIN = 0;
  localparam int ADR_PER  = 1;
  localparam int ADR_BLO  = 2;
  localparam int ADR_BHI  = 3;
  localparam int ADR_STAT = 4;

  // stored bits of the mask words
  localparam logic [31:0] MAIN_IMPL = 32'h0001_FFFF;
  localparam logic [31:0] PER_IMPL  = 32'hFFFF_FC00;

  // request line that carries no source
  localparam logic [NUM_MAIN-1:0] MAIN_LINE_KEEP = ~(NUM_MAIN'(1) << MAIN_BOOST_CODE);

  typedef enum logic [1:0] {
    BOOST_NONE = 2'd0,
    BOOST_MED  = 2'd1,
    BOOST_HIGH = 2'd2,
    BOOST_OFF  = 2'd3
  } boost_e;

  typedef struct packed {
    logic              valid;
    logic [CODE_W-1:0] code;
  } field_t;

  function automatic logic [31:0] pack_status(field_t c, field_t m, field_t p);
    logic [31:0] s;
    s = '0;
    s[CV_BIT]      = c.valid;
    s[CC_LSB +: 2] = 2'(c.code);
    s[MV_BIT]      = m.valid;
    s[MC_LSB +: CODE_W] = m.code;
    s[PV_BIT]      = p.valid;
    s[PC_LSB +: CODE_W] = p.code;
    return s;
  endfunction
endpackage

// File: rtl/arbx_first.sv
module arbx_first
  import arbx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]      vec,
  output logic              hit,
  output logic [CODE_W-1:0] idx
);
  always_comb begin
    hit = |vec;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = CODE_W'(i);
    end
  end
endmodule

// File: rtl/arbx_regs.sv
module arbx_regs
  import arbx_pkg::*;
#(
  parameter logic [31:0] MAIN_RST = 32'h0001_0FFF,
  parameter logic [31:0] PER_RST  = 32'h7FFF_FC00,
  parameter int          ADDR_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [31:0]        wr_data,
  output logic [31:0]        main_word,
  output logic [31:0]        per_word,
  output logic [BOOST_W-1:0] boost_vec
);
  localparam int BHI_W = BOOST_W - 32;

  logic [31:0]      main_q, per_q, blo_q;
  logic [BHI_W-1:0] bhi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      main_q <= MAIN_RST & MAIN_IMPL;
      per_q  <= PER_RST & PER_IMPL;
      blo_q  <= '0;
      bhi_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(ADR_MAIN)) main_q <= wr_data & MAIN_IMPL;
      if (wr_addr == ADDR_W'(ADR_PER))  per_q  <= wr_data & PER_IMPL;
      if (wr_addr == ADDR_W'(ADR_BLO))  blo_q  <= wr_data;
      if (wr_addr == ADDR_W'(ADR_BHI))  bhi_q  <= wr_data[BHI_W-1:0];
    end
  end

  assign main_word = main_q;
  assign per_word  = per_q;
  assign boost_vec = {bhi_q, blo_q};

  AST_MASK_RESET: assert property (@(posedge clk)
    $fell(rst) |-> (main_word == (MAIN_RST & MAIN_IMPL)) && (per_word == (PER_RST & PER_IMPL))
                   && (boost_vec == '0)); // R1
endmodule

// File: rtl/arbx_encode.sv
module arbx_encode
  import arbx_pkg::*;
(
  input  logic [NUM_CRIT-1:0]   crit_q,
  input  logic [NUM_MAIN-1:0]   main_q,
  input  logic [NUM_PERIPH-1:0] per_q,
  input  logic [NUM_MAIN-1:0]   main_dis,
  input  logic [NUM_PERIPH-1:0] per_dis,
  input  logic [BOOST_W-1:0]    boost_vec,
  output field_t                fld_c,
  output field_t                fld_m,
  output field_t                fld_p,
  output logic                  hi_any,
  output logic                  med_any
);
  logic [NUM_PERIPH-1:0] live, hi_vec, med_vec;
  logic [CRIT_CODES-1:0] crit_vec;
  logic [NUM_MAIN-1:0]   main_vec;

  for (genvar n = 0; n < NUM_PERIPH; n++) begin : g_per
    assign live[n]    = per_q[n] & ~per_dis[n];
    assign hi_vec[n]  = live[n] && (boost_vec[2*n +: 2] == BOOST_HIGH);
    assign med_vec[n] = live[n] && (boost_vec[2*n +: 2] == BOOST_MED);
  end

  logic              hi_hit, med_hit, live_hit;
  logic [CODE_W-1:0] hi_idx, med_idx, live_idx;

  arbx_first #(.W(NUM_PERIPH)) u_hi   (.vec(hi_vec),  .hit(hi_hit),   .idx(hi_idx));
  arbx_first #(.W(NUM_PERIPH)) u_med  (.vec(med_vec), .hit(med_hit),  .idx(med_idx));
  arbx_first #(.W(NUM_PERIPH)) u_live (.vec(live),    .hit(live_hit), .idx(live_idx));

  assign hi_any  = hi_hit;
  assign med_any = med_hit;

  // critical codes: line0 -> 0, line1 -> 1, boosted -> 2, line2 -> 3
  assign crit_vec = {crit_q[2], hi_any, crit_q[1], crit_q[0]};

  for (genvar n = 0; n < NUM_MAIN; n++) begin : g_main
    if (n == MAIN_BOOST_CODE) begin : g_redir
      // main_q[n] is held at zero by the request register
      assign main_vec[n] = (med_any | main_q[n]) & ~main_dis[n];
    end else begin : g_line
      assign main_vec[n] = main_q[n] & ~main_dis[n];
    end
  end

  logic              c_hit, m_hit;
  logic [CODE_W-1:0] c_idx, m_idx;

  arbx_first #(.W(CRIT_CODES)) u_crit (.vec(crit_vec), .hit(c_hit), .idx(c_idx));
  arbx_first #(.W(NUM_MAIN))   u_main (.vec(main_vec), .hit(m_hit), .idx(m_idx));

  assign fld_c = '{valid: c_hit, code: c_idx};
  assign fld_m = '{valid: m_hit, code: m_idx};

  always_comb begin
    fld_p.valid = live_hit;
    if (hi_hit)       fld_p.code = hi_idx;
    else if (med_hit) fld_p.code = med_idx;
    else              fld_p.code = live_idx;
  end
endmodule

// File: rtl/irq_tier_arbiter.sv
module irq_tier_arbiter
  import arbx_pkg::*;
#(
  parameter logic [31:0] MAIN_MASK_RST = 32'h0001_0FFF,
  parameter logic [31:0] PER_MASK_RST  = 32'h7FFF_FC00,
  parameter int          ADDR_W        = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_CRIT-1:0]   crit_req,
  input  logic [NUM_MAIN-1:0]   main_req,
  input  logic [NUM_PERIPH-1:0] periph_req,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [31:0]           wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [31:0]           rd_data,
  output logic [31:0]           status
);
  localparam int MAIN_TOP = NUM_MAIN - 1;
  localparam int PER_TOP  = 31;

  logic [NUM_CRIT-1:0]   crit_q;
  logic [NUM_MAIN-1:0]   main_q;
  logic [NUM_PERIPH-1:0] per_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      crit_q <= '0;
      main_q <= '0;
      per_q  <= '0;
    end else begin
      crit_q <= crit_req;
      main_q <= main_req & MAIN_LINE_KEEP;
      per_q  <= periph_req;
    end
  end

  logic [31:0]        main_word, per_word;
  logic [BOOST_W-1:0] boost_vec;

  arbx_regs #(
    .MAIN_RST(MAIN_MASK_RST), .PER_RST(PER_MASK_RST), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .main_word(main_word), .per_word(per_word), .boost_vec(boost_vec)
  );

  // mask words are numbered from the top bit down
  logic [NUM_MAIN-1:0]   main_dis;
  logic [NUM_PERIPH-1:0] per_dis;
  for (genvar n = 0; n < NUM_MAIN; n++) begin : g_mdis
    assign main_dis[n] = main_word[MAIN_TOP - n];
  end
  for (genvar n = 0; n < NUM_PERIPH; n++) begin : g_pdis
    assign per_dis[n] = per_word[PER_TOP - n];
  end

  field_t fld_c, fld_m, fld_p;
  logic   hi_any, med_any;

  arbx_encode u_enc (
    .crit_q(crit_q), .main_q(main_q), .per_q(per_q),
    .main_dis(main_dis), .per_dis(per_dis), .boost_vec(boost_vec),
    .fld_c(fld_c), .fld_m(fld_m), .fld_p(fld_p),
    .hi_any(hi_any), .med_any(med_any)
  );

  assign status = pack_status(fld_c, fld_m, fld_p);

  always_comb begin
    unique case (rd_addr)
      ADDR_W'(ADR_MAIN): rd_data = main_word;
      ADDR_W'(ADR_PER):  rd_data = per_word;
      ADDR_W'(ADR_BLO):  rd_data = boost_vec[31:0];
      ADDR_W'(ADR_BHI):  rd_data = 32'(boost_vec[BOOST_W-1:32]);
      ADDR_W'(ADR_STAT): rd_data = status;
      default:           rd_data = '0;
    endcase
  end

  AST_REQ_SAMPLED: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(crit_req[0]) |-> status[CV_BIT] && (status[CC_LSB +: 2] == 2'd0)); // R4

  AST_HIGH_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    fld_c.valid && (fld_c.code == CODE_W'(CRIT_BOOST_CODE))
      |-> fld_p.valid && (boost_vec[2*fld_p.code +: 2] == BOOST_HIGH)); // R5

  AST_MED_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    fld_m.valid && (fld_m.code == CODE_W'(MAIN_BOOST_CODE)) |-> fld_p.valid && med_any); // R6

  AST_MAIN_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    fld_m.valid |-> !main_dis[fld_m.code]); // R6

  AST_PER_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    fld_p.valid |-> !per_dis[fld_p.code] && per_q[fld_p.code]); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!status[CV_BIT] |-> status[CC_LSB +: 2] == 2'd0) and
    (!status[MV_BIT] |-> status[MC_LSB +: CODE_W] == '0) and
    (!status[PV_BIT] |-> status[PC_LSB +: CODE_W] == '0)); // R8
endmodule

// File: tb/irq_tier_arbiter_test.sv
module irq_tier_arbiter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  crit_req = '0;
  logic [16:0] main_req = '0;
  logic [21:0] periph_req = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = 3'd4;
  logic [31:0] rd_data, status;

  int checks = 0;
  int failures = 0;

  // bench copy of programmed state
  logic [31:0] mm, pm;
  logic [43:0] bst;
  logic [2:0]  cr;
  logic [16:0] mr;
  logic [21:0] pr;
  logic [31:0] seed = 32'h1234_5678;

  irq_tier_arbiter uut (
    .clk(clk), .rst(rst), .crit_req(crit_req), .main_req(main_req), .periph_req(periph_req),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .status(status)
  );

  always #10 clk = ~clk;

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog R4 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [31:0] nxt(input logic [31:0] v);
    logic [31:0] x = v;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  // status expected from the requirements
  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    int hi = -1, md = -1, lv = -1, cc = -1, mc = -1, pc;
    for (int n = 0; n < 22; n++) begin
      if (pr[n] && !pm[31 - n]) begin
        if (lv < 0) lv = n;
        if (bst[2*n +: 2] == 2'd2 && hi < 0) hi = n;
        if (bst[2*n +: 2] == 2'd1 && md < 0) md = n;
      end
    end
    if (lv >= 0) begin
      pc = (hi >= 0) ? hi : ((md >= 0) ? md : lv);
      s = s | (32'h1 << 29) | (32'(pc) << 24);
    end
    if (cr[0]) cc = 0;
    else if (cr[1]) cc = 1;
    else if (hi >= 0) cc = 2;
    else if (cr[2]) cc = 3;
    if (cc >= 0) s = s | (32'h1 << 10) | (32'(cc) << 8);
    for (int n = 0; n < 17; n++) begin
      if (mc < 0) begin
        if (n == 4) begin
          if (md >= 0 && !mm[12]) mc = 4;
        end else if (mr[n] && !mm[16 - n]) mc = n;
      end
    end
    if (mc >= 0) s = s | (32'h1 << 21) | (32'(mc) << 16);
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic put_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cfg(input logic [31:0] m, input logic [31:0] p, input logic [43:0] b);
    mm = m & 32'h0001_FFFF; pm = p & 32'hFFFF_FC00; bst = b;
    put_reg(3'd0, m); put_reg(3'd1, p);
    put_reg(3'd2, b[31:0]); put_reg(3'd3, {20'b0, b[43:32]});
  endtask

  task automatic set_req(input logic [2:0] c, input logic [16:0] m, input logic [21:0] p);
    @(negedge clk);
    crit_req = c; main_req = m; periph_req = p;
    cr = c; mr = m; pr = p;
    @(negedge clk);
  endtask

  task automatic req_chk(input string tag, input logic [2:0] c, input logic [16:0] m,
                         input logic [21:0] p);
    set_req(c, m, p);
    chk(tag, status, exp_status());
  endtask

  initial begin
    logic [31:0] d;
    mm = 32'h0001_0FFF; pm = 32'h7FFF_FC00; bst = '0; cr = '0; mr = '0; pr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, d); chk("R1 main mask", d, 32'h0001_0FFF);
    rd(3'd1, d); chk("R1 periph mask", d, 32'h7FFF_FC00);
    rd(3'd2, d); chk("R1 boost lo", d, 32'h0);
    rd(3'd3, d); chk("R1 boost hi", d, 32'h0);
    rd(3'd4, d); chk("R8 idle status", d, 32'h0);
    chk("R8 idle status port", status, 32'h0);
    // reset masks: peripheral source 0 enabled, source 5 disabled
    req_chk("R1 reset mask p0", 3'b0, 17'b0, 22'h1);
    req_chk("R1 reset mask p5", 3'b0, 17'b0, 22'h20);

    // R2 register map
    put_reg(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); chk("R2 main stored bits", d, 32'h0001_FFFF);
    put_reg(3'd1, 32'hFFFF_FFFF); rd(3'd1, d); chk("R2 periph stored bits", d, 32'hFFFF_FC00);
    put_reg(3'd2, 32'hFFFF_FFFF); rd(3'd2, d); chk("R2 boost lo", d, 32'hFFFF_FFFF);
    put_reg(3'd3, 32'hFFFF_FFFF); rd(3'd3, d); chk("R2 boost hi", d, 32'h0000_0FFF);
    put_reg(3'd4, 32'h0); put_reg(3'd5, 32'h0); put_reg(3'd7, 32'h0);
    rd(3'd0, d); chk("R2 ignored write main", d, 32'h0001_FFFF);
    rd(3'd1, d); chk("R2 ignored write periph", d, 32'hFFFF_FC00);
    rd(3'd3, d); chk("R2 ignored write boost", d, 32'h0000_0FFF);
    rd(3'd6, d); chk("R2 unused address", d, 32'h0);

    set_cfg(32'h0, 32'h0, 44'h0);

    // R4 latency
    set_req(3'b0, 17'b0, 22'b0);
    crit_req = 3'b001; cr = 3'b001;
    #2; chk("R4 before edge", status, 32'h0);
    @(negedge clk); chk("R4 after edge", status, 32'h0000_0400);
    rd(3'd4, d); chk("R3 status readback", d, 32'h0000_0400);

    // R5 critical singles and pairs
    for (int k = 0; k < 8; k++) req_chk("R5 crit pattern", 3'(k), 17'b0, 22'b0);
    // R6 main singles, line 4 ignored
    for (int n = 0; n < 17; n++) req_chk("R6 main single", 3'b0, 17'(1) << n, 22'b0);
    // R7 periph singles
    for (int n = 0; n < 22; n++) req_chk("R7 periph single", 3'b0, 17'b0, 22'(1) << n);
    // R6 and R7 masks
    for (int n = 0; n < 17; n++) begin
      set_cfg(32'h1 << (16 - n), 32'h0, 44'h0);
      req_chk("R6 main masked", 3'b0, 17'(1) << n, 22'b0);
    end
    for (int n = 0; n < 22; n++) begin
      set_cfg(32'h0, 32'h1 << (31 - n), 44'h0);
      req_chk("R7 periph masked", 3'b0, 17'b0, 22'(1) << n);
    end
    set_cfg(32'h0, 32'h0, 44'h0);
    // R6 R7 pairwise priority
    for (int i = 0; i < 17; i++)
      for (int j = i + 1; j < 17; j++)
        req_chk("R6 main pair", 3'b0, (17'(1) << i) | (17'(1) << j), 22'b0);
    for (int i = 0; i < 22; i++)
      for (int j = i + 1; j < 22; j++)
        req_chk("R7 periph pair", 3'b0, 17'b0, (22'(1) << i) | (22'(1) << j));

    // R5 R6 R7 boosts on each source with source 0 also pending
    for (int n = 1; n < 22; n++) begin
      set_cfg(32'h0, 32'h0, 44'h2 << (2 * n));
      req_chk("R5 high boost", 3'b0, 17'b0, (22'(1) << n) | 22'h1);
      req_chk("R5 high boost under line0", 3'b001, 17'b0, (22'(1) << n) | 22'h1);
      req_chk("R5 high boost over line2", 3'b100, 17'b0, (22'(1) << n) | 22'h1);
      set_cfg(32'h0, 32'h0, 44'h1 << (2 * n));
      req_chk("R6 medium boost", 3'b0, 17'h20, (22'(1) << n) | 22'h1);
      req_chk("R6 medium boost vs line0", 3'b0, 17'h1, (22'(1) << n) | 22'h1);
      set_cfg(32'h1000, 32'h0, 44'h1 << (2 * n));
      req_chk("R6 redirect masked", 3'b0, 17'b0, (22'(1) << n) | 22'h1);
      set_cfg(32'h0, 32'h0, 44'h3 << (2 * n));
      req_chk("R7 boost code 3", 3'b0, 17'b0, (22'(1) << n) | 22'h1);
    end

    // R3 R5 R6 R7 R8 pseudo-random patterns with full model compare
    for (int it = 0; it < 1600; it++) begin
      logic [31:0] a, b, c;
      if (it % 40 == 0) begin
        seed = nxt(seed); a = seed; seed = nxt(seed);
        b = seed; seed = nxt(seed); c = seed;
        set_cfg(a & b & c, (a ^ c) & b, {b[11:0], c});
      end
      seed = nxt(seed); a = seed; seed = nxt(seed); b = seed;
      req_chk("R3 random", a[2:0] & b[2:0], a[16:0] & b[20:4], a[31:10] & b[21:0]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule